// File: doc/BRIEF.md
# Sectioned Tapped Shift Register

Four independent single-bit serial shift sections share one clock and one active-low asynchronous reset. Two sections are four stages deep. The other two are five stages deep and expose a tap after their fourth stage as well as their last one. All stages advance on the falling clock edge and keep their contents for as long as the clock rests at either level. The first section also drives a late copy of its fourth-stage output, re-timed by half a clock period through a latch that is open while the clock is high. A stage that receives this late copy is still safe when its clock edges are slow.

A build-time switch places a router in front of the sections. The router joins them into one serial register whose length is chosen by a length code. The serial input is then bit 0 of the data bus, and the chained result leaves on its own output. With the switch off, each section takes its own data bit and the chained output mirrors the last tap of the fourth section.

Top module: `tap_shift_quad`

## Requirements
- R1: While rst_ni is low, every tap, the late output and chain_o are 0, and they go to 0 without waiting for a clock edge.
- R2: A rising clock edge changes no stage; taps sampled in the high phase equal the values sampled in the preceding low phase.
- R3: Sections A (data bit 0) and C (data bit 2) are four stages deep: a4_o and c4_o show the input bit as it was at the fourth-most-recent falling edge.
- R4: Sections B (data bit 1) and D (data bit 3) are five stages deep: b4_o and d4_o show the input as it was at the fourth-most-recent falling edge, and b5_o and d5_o show it as it was at the fifth-most-recent.
- R5: In separate mode (CHAIN_EN=0) the sections are independent: activity on one data bit never reaches the taps of another section.
- R6: With the clock stopped high or low, all outputs hold their values whatever the data inputs do.
- R7: a4_late_o equals a4_o while the clock is high, and during the low phase it keeps the value a4_o had before the last falling edge.
- R8: In chained mode (CHAIN_EN=1), for a length code of 10, 12, 13, 14, 16, 17 or 18 (the code is the length in binary on len_sel_i), chain_o shows ser_i[0] as it was that many falling edges ago.
- R9: In chained mode, any other length code selects the full 18-stage chain.
- R10: In chained mode, ser_i[3:1] has no effect on chain_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared shift clock; stages advance on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 4 | Serial data, bit s feeds section s (A..D); in chained mode only bit 0 is used |
| len_sel_i | input | 5 | Chained length in binary; unsupported codes mean 18 |
| a4_o | output | 1 | Section A, stage 4 |
| a4_late_o | output | 1 | Section A, stage 4, delayed half a clock period |
| b4_o | output | 1 | Section B, stage 4 |
| b5_o | output | 1 | Section B, stage 5 |
| c4_o | output | 1 | Section C, stage 4 |
| d4_o | output | 1 | Section D, stage 4 |
| d5_o | output | 1 | Section D, stage 5 |
| chain_o | output | 1 | End of the chained register (CHAIN_EN=1), else mirror of d5_o |

## Verification
The bench builds two copies side by side from the same stimulus: one with CHAIN_EN=0 and one with CHAIN_EN=1. The separate-mode copy makes each section's depth, both mid taps, the half-cycle latch and the isolation between sections visible at the ports. The chained copy is run through every supported length code and two unsupported codes while noise is driven on the unused data bits. This exposes the routing of every section combination and the fallback to 18 stages.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int N_SECT    = 4;
  localparam int SHORT_LEN = 4;
  localparam int LONG_LEN  = 5;
  localparam int LEN_W     = 5;
  localparam int MAX_LEN   = 2 * SHORT_LEN + 2 * LONG_LEN;

  typedef struct packed {
    logic [N_SECT-1:0] use_sect;   // section is part of the chain
    logic [N_SECT-1:0] long_sect;  // take the last tap instead of the stage-4 tap
  } chain_cfg_t;

  // odd-numbered sections (B, D) are the long ones
  function automatic int sect_depth(input int s);
    return (s % 2 == 1) ? LONG_LEN : SHORT_LEN;
  endfunction

  function automatic chain_cfg_t decode_len(input logic [LEN_W-1:0] code);
    chain_cfg_t c;
    case (code)
      5'd10:   begin c.use_sect = 4'b1010; c.long_sect = 4'b1010; end
      5'd12:   begin c.use_sect = 4'b0111; c.long_sect = 4'b0000; end
      5'd13:   begin c.use_sect = 4'b1101; c.long_sect = 4'b1000; end
      5'd14:   begin c.use_sect = 4'b1011; c.long_sect = 4'b1010; end
      5'd16:   begin c.use_sect = 4'b1111; c.long_sect = 4'b0000; end
      5'd17:   begin c.use_sect = 4'b1111; c.long_sect = 4'b0010; end
      default: begin c.use_sect = 4'b1111; c.long_sect = 4'b1010; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/stage_chain.sv
module stage_chain #(
  parameter int DEPTH = 4,
  parameter int TAP   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic tap_o,
  output logic last_o
);
  logic [DEPTH-1:0] stg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEPTH-2:0], d_i};
  end

  assign tap_o  = stg_q[TAP-1];
  assign last_o = stg_q[DEPTH-1];

  // R3 R4
  shift_in_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stg_q[0] == $past(d_i)));

  // R3 R4
  shift_thru_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stg_q[DEPTH-1:1] == $past(stg_q[DEPTH-2:0])));
endmodule

// File: rtl/phase_latch.sv
module phase_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  // open while the clock is high
  always_latch begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clk_i) q_o <= d_i;
  end

  // R7
  late_follow_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    q_o == d_i);
endmodule

// File: rtl/chain_router.sv
module chain_router
  import sreg_pkg::*;
(
  input  logic              ser_i,
  input  chain_cfg_t        cfg_i,
  input  logic [N_SECT-1:0] tap4_i,
  input  logic [N_SECT-1:0] tap_end_i,
  output logic [N_SECT-1:0] sect_in_o,
  output logic              chain_o
);
  always_comb begin
    logic feed;
    feed = ser_i;
    for (int s = 0; s < N_SECT; s++) begin
      sect_in_o[s] = feed;
      if (cfg_i.use_sect[s])
        feed = cfg_i.long_sect[s] ? tap_end_i[s] : tap4_i[s];
    end
    chain_o = feed;
  end
endmodule

// File: rtl/tap_shift_quad.sv
module tap_shift_quad
  import sreg_pkg::*;
#(
  parameter bit CHAIN_EN = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       ser_i,
  input  logic [LEN_W-1:0] len_sel_i,
  output logic             a4_o,
  output logic             a4_late_o,
  output logic             b4_o,
  output logic             b5_o,
  output logic             c4_o,
  output logic             d4_o,
  output logic             d5_o,
  output logic             chain_o
);
  logic [N_SECT-1:0] sect_in, tap4, tap_end, routed_in;
  logic              routed_out;
  chain_cfg_t        cfg;

  assign cfg = decode_len(len_sel_i);

  chain_router u_router (
    .ser_i     (ser_i[0]),
    .cfg_i     (cfg),
    .tap4_i    (tap4),
    .tap_end_i (tap_end),
    .sect_in_o (routed_in),
    .chain_o   (routed_out)
  );

  assign sect_in = CHAIN_EN ? routed_in : ser_i;

  for (genvar s = 0; s < N_SECT; s++) begin : g_sect
    localparam int DEPTH = sect_depth(s);
    stage_chain #(.DEPTH(DEPTH), .TAP(SHORT_LEN)) u_stages (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sect_in[s]),
      .tap_o  (tap4[s]),
      .last_o (tap_end[s])
    );
  end

  phase_latch u_late (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tap4[0]),
    .q_o    (a4_late_o)
  );

  assign a4_o    = tap4[0];
  assign b4_o    = tap4[1];
  assign b5_o    = tap_end[1];
  assign c4_o    = tap4[2];
  assign d4_o    = tap4[3];
  assign d5_o    = tap_end[3];
  assign chain_o = CHAIN_EN ? routed_out : tap_end[3];

  // R1
  reset_clear_chk: assert property (@(negedge clk_i)
    !rst_ni |-> ({a4_o, a4_late_o, b4_o, b5_o, c4_o, d4_o, d5_o, chain_o} == 8'h00));
endmodule

// File: tb/sim_tap_shift_quad.sv
module sim_tap_shift_quad;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b1;
  logic [3:0] ser = 4'h0;
  logic [4:0] len_sel = 5'd18;
  int n_vec = 0;
  int n_bad = 0;

  logic a4, a4l, b4, b5, c4, d4, d5, ch0;
  logic xa4, xa4l, xb4, xb5, xc4, xd4, xd5, ch1;

  tap_shift_quad #(.CHAIN_EN(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .len_sel_i(len_sel),
    .a4_o(a4), .a4_late_o(a4l), .b4_o(b4), .b5_o(b5), .c4_o(c4),
    .d4_o(d4), .d5_o(d5), .chain_o(ch0));

  tap_shift_quad #(.CHAIN_EN(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .len_sel_i(len_sel),
    .a4_o(xa4), .a4_late_o(xa4l), .b4_o(xb4), .b5_o(xb5), .c4_o(xc4),
    .d4_o(xd4), .d5_o(xd5), .chain_o(ch1));

  initial forever begin
    #HALF;
    if (clk_run) clk = ~clk;
  end

  // expected-delay model: bit k = input seen k+1 falling edges ago
  logic [31:0] hist [4];
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) for (int s = 0; s < 4; s++) hist[s] <= '0;
    else        for (int s = 0; s < 4; s++) hist[s] <= {hist[s][30:0], ser[s]};
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic taps_vs_model(input string tag);
    chk({tag, " R3 a4"}, a4, hist[0][3]);
    chk({tag, " R4 b4"}, b4, hist[1][3]);
    chk({tag, " R4 b5"}, b5, hist[1][4]);
    chk({tag, " R3 c4"}, c4, hist[2][3]);
    chk({tag, " R4 d4"}, d4, hist[3][3]);
    chk({tag, " R4 d5"}, d5, hist[3][4]);
  endtask

  // one clock: check low phase, check high phase, drive new data
  task automatic cycle(input logic [3:0] mask, input int chain_len, input bit do_chk);
    @(negedge clk); #2;
    if (do_chk) begin
      taps_vs_model("low");
      chk("R7 late holds in low phase", a4l, hist[0][4]);
      if (chain_len > 0) chk("R8 R9 R10 chain_o", ch1, hist[0][chain_len-1]);
    end
    @(posedge clk); #2;
    if (do_chk) begin
      taps_vs_model("R2 high");
      chk("R7 late follows in high phase", a4l, hist[0][3]);
    end
    #1 ser = 4'($urandom) & mask;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk("R1 a4",   a4,  1'b0);
    chk("R1 late", a4l, 1'b0);
    chk("R1 b5",   b5,  1'b0);
    chk("R1 d5",   d5,  1'b0);
    chk("R1 chain", ch1, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic test_reset();
    ser = 4'hF;
    for (int i = 0; i < 8; i++) cycle(4'hF, 0, 1'b0);
    do_reset();
  endtask

  task automatic test_random_streams();
    for (int i = 0; i < 60; i++) cycle(4'hF, 0, 1'b1);
  endtask

  task automatic test_isolation();
    do_reset();
    ser = 4'h0;
    for (int i = 0; i < 12; i++) begin
      cycle(4'b0100, 0, 1'b1);
      chk("R5 other sections quiet", a4 | b4 | b5 | d4 | d5, 1'b0);
    end
    for (int i = 0; i < 10; i++) cycle(4'hF, 0, 1'b0);
  endtask

  task automatic test_hold(input bit at_high);
    logic [6:0] keep;
    if (at_high) begin @(posedge clk); #2; end
    else         begin @(negedge clk); #2; end
    clk_run = 1'b0;
    keep = {a4, a4l, b4, b5, c4, d4, d5};
    for (int i = 0; i < 20; i++) begin
      #(CLK_PERIOD * 3) ser = 4'($urandom);
      chk(at_high ? "R6 hold clock high" : "R6 hold clock low",
          ({a4, a4l, b4, b5, c4, d4, d5} == keep), 1'b1);
    end
    clk_run = 1'b1;
    for (int i = 0; i < 8; i++) cycle(4'hF, 0, 1'b1);
  endtask

  task automatic test_chain();
    int codes [9] = '{10, 12, 13, 14, 16, 17, 18, 0, 7};
    for (int k = 0; k < 9; k++) begin
      int eff;
      eff = (codes[k] == 0 || codes[k] == 7) ? 18 : codes[k];
      @(posedge clk); #3;
      len_sel = 5'(codes[k]);
      for (int i = 0; i < 20; i++) cycle(4'hF, 0, 1'b0);
      for (int i = 0; i < 14; i++) cycle(4'hF, eff, 1'b1);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    report();
  end

  initial begin
    #1 rst_n = 1'b0;
    #(CLK_PERIOD * 2);
    chk("R1 reset state a4", a4, 1'b0);
    chk("R1 reset state late", a4l, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    test_random_streams();
    test_reset();
    test_random_streams();
    test_isolation();
    test_hold(1'b0);
    test_hold(1'b1);
    test_chain();
    report();
  end
endmodule